// File: doc/BRIEF.md
# Configurable Registered Output Cell

This block is the output stage that sits after one OR sum of a programmable sum-of-products array. It can pass the sum straight to the pin, or it can pass it through a D flip-flop clocked by the global clock. It can also invert the signal before the output driver. A dedicated enable term gates the driver.

A feedback line returns a signal to the logic array. In the registered modes this is the inverted flip-flop state. In the combinational modes it is the sum itself. The flip-flop has two controls. A clear term acts asynchronously. A preset term acts on the next rising edge.

A two-bit mode code selects the configuration. Its upper bit picks the path and its lower bit picks the polarity. The pad itself is modelled only as a value and an enable.

Top module: `output_macrocell`

## Requirements
- R1: `cell_mode` is read as {path, polarity}. The four codes are: 2'b00 registered with the pin inverted, 2'b01 registered with the pin true, 2'b10 combinational with the pin inverted, and 2'b11 combinational with the pin true.
- R2: In a registered mode, the pin shows the value that the flip-flop captured from `sum_term` on the last rising clock edge. The pin does not change between edges.
- R3: In a combinational mode, the pin follows `sum_term` in the same cycle, with no clock edge needed. It is inverted when the polarity bit is 0.
- R4: In a registered mode, `fb_out` is the inverse of the flip-flop state. The polarity bit has no effect on it.
- R5: In a combinational mode, `fb_out` equals `sum_term`. The polarity bit has no effect on it.
- R6: When `preset_term` is 1 at a rising edge, the flip-flop becomes 1, whatever `sum_term` is.
- R7: When `clear_term` is 1, the flip-flop is 0 at once, without waiting for a clock edge. This holds whatever the values of `preset_term`, `sum_term` and the clock.
- R8: `pin_oe` equals `oe_term`. While `oe_term` is 0, `pin_out` is held at 0, which stands for a high-impedance pin.
- R9: While the driver is disabled, `fb_out` still carries the signal that the mode selects.
- R10: In the combinational modes the flip-flop keeps loading on every edge. Switching to a registered mode then shows the value that was last captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock. The flip-flop loads on its rising edge. |
| sum_term | input | 1 | OR sum from the array. |
| oe_term | input | 1 | Output-enable product term. |
| preset_term | input | 1 | Synchronous preset term, active high. |
| clear_term | input | 1 | Asynchronous clear term, active high. |
| cell_mode | input | 2 | Mode code {path, polarity}. |
| pin_out | output | 1 | Value driven to the pad. |
| pin_oe | output | 1 | Pad driver enable. |
| fb_out | output | 1 | Feedback to the logic array. |

## Verification
A wrong flip-flop state appears at `fb_out` straight after the edge that loaded it, whenever the cell is in a registered mode. It also appears on `pin_out` in that same cycle, if the driver is enabled. While the cell is in a combinational mode, a bad stored value stays hidden. It shows up only in the cycle in which the mode returns to a registered code, which is why the tests switch modes on purpose. A wrong polarity or path decode can be seen on the pin combinationally, within the cycle in which the mode is applied.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        MODE_REG_INV  = 2'b00,
        MODE_REG_TRUE = 2'b01,
        MODE_CMB_INV  = 2'b10,
        MODE_CMB_TRUE = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic value;
        logic enable;
        logic feedback;
    } pad_drive_t;

    function automatic logic mode_is_comb(input cell_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_true(input cell_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/mc_store.sv
module mc_store #(
    parameter logic CLEAR_VALUE  = 1'b0,
    parameter logic PRESET_VALUE = 1'b1
) (
    input  logic clk,
    input  logic clear_term,
    input  logic preset_term,
    input  logic d_in,
    output logic q_out
);

    always_ff @(posedge clk or posedge clear_term) begin
        if (clear_term)
            q_out <= CLEAR_VALUE;
        else if (preset_term)
            q_out <= PRESET_VALUE;
        else
            q_out <= d_in;
    end

endmodule

// File: rtl/mc_route.sv
module mc_route
    import mc_pkg::*;
(
    input  cell_mode_e mode,
    input  logic       sum_term,
    input  logic       q_state,
    input  logic       oe_term,
    output pad_drive_t drive
);

    logic picked;
    logic shaped;

    always_comb begin
        picked = mode_is_comb(mode) ? sum_term : q_state;
        shaped = mode_is_true(mode) ? picked : ~picked;

        drive.enable   = oe_term;
        drive.value    = oe_term ? shaped : 1'b0;
        drive.feedback = mode_is_comb(mode) ? sum_term : ~q_state;
    end

endmodule

// File: rtl/output_macrocell.sv
module output_macrocell
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       sum_term,
    input  logic       oe_term,
    input  logic       preset_term,
    input  logic       clear_term,
    input  logic [1:0] cell_mode,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       fb_out
);

    cell_mode_e mode_dec;
    logic       q_state;
    pad_drive_t drive;

    assign mode_dec = cell_mode_e'(cell_mode);

    mc_store u_store (
        .clk         (clk),
        .clear_term  (clear_term),
        .preset_term (preset_term),
        .d_in        (sum_term),
        .q_out       (q_state)
    );

    mc_route u_route (
        .mode     (mode_dec),
        .sum_term (sum_term),
        .q_state  (q_state),
        .oe_term  (oe_term),
        .drive    (drive)
    );

    assign pin_out = drive.value;
    assign pin_oe  = drive.enable;
    assign fb_out  = drive.feedback;

endmodule

// File: rtl/mc_checker.sv
module mc_checker (
    input logic       clk,
    input logic       sum_term,
    input logic       oe_term,
    input logic       preset_term,
    input logic       clear_term,
    input logic [1:0] cell_mode,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       fb_out
);

    AST_CMB_PIN: assert property (@(posedge clk) disable iff (clear_term)
        (cell_mode[1] && oe_term) |-> (pin_out == (cell_mode[0] ? sum_term : ~sum_term))); // R3

    AST_CMB_FB: assert property (@(posedge clk) disable iff (clear_term)
        cell_mode[1] |-> (fb_out == sum_term)); // R5

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (clear_term)
        (!preset_term && !cell_mode[1]) |=> (cell_mode[1] || fb_out == ~$past(sum_term))); // R4

    AST_PRESET_SET: assert property (@(posedge clk) disable iff (clear_term)
        preset_term |=> (cell_mode[1] || fb_out == 1'b0)); // R6

    AST_CLEAR_HOLD: assert property (@(posedge clk)
        (clear_term && $past(clear_term) && !cell_mode[1]) |-> (fb_out == 1'b1)); // R7

    AST_OE_FOLLOW: assert property (@(posedge clk)
        (pin_oe == oe_term) && (oe_term || pin_out == 1'b0)); // R8

endmodule

bind output_macrocell mc_checker u_chk (
    .clk         (clk),
    .sum_term    (sum_term),
    .oe_term     (oe_term),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .cell_mode   (cell_mode),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .fb_out      (fb_out)
);

// File: tb/sim_output_macrocell.sv
module sim_output_macrocell;

    logic       clk = 1'b0;
    logic       sum_term = 1'b0;
    logic       oe_term = 1'b1;
    logic       preset_term = 1'b0;
    logic       clear_term = 1'b1;
    logic [1:0] cell_mode = 2'b01;
    logic       pin_out;
    logic       pin_oe;
    logic       fb_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    output_macrocell u0 (
        .clk         (clk),
        .sum_term    (sum_term),
        .oe_term     (oe_term),
        .preset_term (preset_term),
        .clear_term  (clear_term),
        .cell_mode   (cell_mode),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .fb_out      (fb_out)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic edge_then_settle();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        #2;
        chk("R7 reset pin", pin_out, 1'b0);
        chk("R7 reset fb", fb_out, 1'b1);
        @(negedge clk);
        clear_term = 1'b0;
    endtask

    task automatic t_comb();
        @(negedge clk);
        cell_mode = 2'b11; sum_term = 1'b1; #1;
        chk("R3 comb true", pin_out, 1'b1);
        chk("R5 comb fb", fb_out, 1'b1);
        cell_mode = 2'b10; #1;
        chk("R1 comb inv", pin_out, 1'b0);
        chk("R5 fb no polarity", fb_out, 1'b1);
        sum_term = 1'b0; #1;
        chk("R3 comb inv low", pin_out, 1'b1);
        chk("R5 fb low", fb_out, 1'b0);
    endtask

    task automatic t_reg();
        @(negedge clk);
        cell_mode = 2'b01; sum_term = 1'b0;
        edge_then_settle();
        @(negedge clk);
        sum_term = 1'b1; #1;
        chk("R2 hold before edge", pin_out, 1'b0);
        edge_then_settle();
        chk("R2 reg true", pin_out, 1'b1);
        chk("R4 reg fb", fb_out, 1'b0);
        cell_mode = 2'b00; #1;
        chk("R1 reg inv", pin_out, 1'b0);
        chk("R4 fb no polarity", fb_out, 1'b0);
    endtask

    task automatic t_preset();
        @(negedge clk);
        cell_mode = 2'b01; sum_term = 1'b0;
        edge_then_settle();
        chk("R2 loaded zero", pin_out, 1'b0);
        @(negedge clk);
        preset_term = 1'b1;
        edge_then_settle();
        chk("R6 preset over D", pin_out, 1'b1);
        chk("R6 preset fb", fb_out, 1'b0);
        @(negedge clk);
        preset_term = 1'b0;
    endtask

    task automatic t_clear();
        @(negedge clk);
        cell_mode = 2'b01; sum_term = 1'b1;
        edge_then_settle();
        chk("R2 loaded one", pin_out, 1'b1);
        #1;
        clear_term = 1'b1; #1;
        chk("R7 async clear", pin_out, 1'b0);
        preset_term = 1'b1;
        edge_then_settle();
        chk("R7 clear over preset", pin_out, 1'b0);
        @(negedge clk);
        clear_term = 1'b0; preset_term = 1'b0;
    endtask

    task automatic t_oe();
        @(negedge clk);
        cell_mode = 2'b11; sum_term = 1'b1; oe_term = 1'b0; #1;
        chk("R8 oe low", pin_oe, 1'b0);
        chk("R8 pin held", pin_out, 1'b0);
        chk("R9 fb comb disabled", fb_out, 1'b1);
        cell_mode = 2'b01;
        edge_then_settle();
        chk("R9 fb reg disabled", fb_out, 1'b0);
        oe_term = 1'b1; #1;
        chk("R8 oe high", pin_oe, 1'b1);
        chk("R8 pin back", pin_out, 1'b1);
    endtask

    task automatic t_comb_clocks();
        @(negedge clk);
        cell_mode = 2'b11; sum_term = 1'b0;
        edge_then_settle();
        @(negedge clk);
        sum_term = 1'b1;
        edge_then_settle();
        @(negedge clk);
        sum_term = 1'b0; cell_mode = 2'b01; #1;
        chk("R10 hidden capture", pin_out, 1'b1);
        chk("R10 hidden fb", fb_out, 1'b0);
    endtask

    initial begin
        t_reset();
        t_comb();
        t_reg();
        t_preset();
        t_clear();
        t_oe();
        t_comb_clocks();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule